// File: doc/BRIEF.md
# Operand Forwarding Control with Bypassing Register File

This block decides, for each of the two ALU operands of the instruction that enters the execute stage of a five-stage in-order integer pipeline, where the operand value should come from. Each source register number is compared against the destination register numbers and write flags held in the two later pipeline registers. These are the execute/memory register, whose producer is one instruction ahead, and the memory/writeback register, whose producer is two instructions ahead. The result is a 2-bit select per operand.

The top level wraps that control with the two operand multiplexers and a small register file. The register file hands a value being written in the current cycle straight through to a read of the same register. With this wrapper, the values the ALU would see can be observed directly at the ports. Register zero is hard-wired: it never forwards, never bypasses and always reads as zero. Stall generation and branch handling are outside this block.

Top module: `fwd_unit_top`

## Requirements
- R1: When operand A's source `rs_addr` (or operand B's source `rt_addr`) equals `em_rd`, `em_we` is 1 and the register is nonzero, the select for that operand is 2'b10. The operand then equals `em_data`. The select value 2'b11 never appears.
- R2: When there is no qualifying execute/memory match, and the source equals `mw_rd` with `mw_we` at 1 and a nonzero register, the select is 2'b01 and the operand equals `mw_data`.
- R3: When neither later stage qualifies, the select is 2'b00 and the operand equals the register file read of the source register.
- R4: A stage whose write flag (`em_we` or `mw_we`) is 0 never produces a forward, even if its destination number matches.
- R5: A source or destination of register 0 never produces a forward. The select stays 2'b00 and the operand reads zero.
- R6: When both stages match the same source, the execute/memory value wins (select 2'b10).
- R7: Operand A is decided only from `rs_addr` and operand B only from `rt_addr`. In the same cycle they may pick different sources.
- R8: When `wb_we` is 1 and `wb_rd` is nonzero and equals a read address, that read returns `wb_data` in the same cycle.
- R9: A write to a nonzero register is stored at the clock edge and returned by later reads. A write to register 0 is discarded.
- R10: While `rst_n` is low, every register is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rs_addr | input | 5 | First source register of the execute-stage instruction |
| rt_addr | input | 5 | Second source register of the execute-stage instruction |
| em_we | input | 1 | Execute/memory register-write flag |
| em_rd | input | 5 | Execute/memory destination register |
| em_data | input | DATA_W | Execute/memory result value |
| mw_we | input | 1 | Memory/writeback register-write flag |
| mw_rd | input | 5 | Memory/writeback destination register |
| mw_data | input | DATA_W | Memory/writeback result value |
| wb_we | input | 1 | Register file write enable |
| wb_rd | input | 5 | Register file write address |
| wb_data | input | DATA_W | Register file write data |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | DATA_W | Selected operand A value |
| opnd_b | output | DATA_W | Selected operand B value |

## Verification
The bench targets the cases where both later stages name the same register. A design with the priority reversed would hand the older memory/writeback value to the ALU. It drives matching destinations with the write flag low; a design ignoring the flag would forward stale data from a store or branch. It also aims register 0 at both forwarding paths and at the register file write port, where a design without the zero guard would return a nonzero value for register zero. Finally, it writes and reads the same register in one cycle, where a file lacking the bypass returns the previous contents.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        SRC_FILE  = 2'b00,
        SRC_MEMWB = 2'b01,
        SRC_EXMEM = 2'b10
    } fwd_src_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] src_reg,
    input  logic              em_we,
    input  logic [ADDR_W-1:0] em_rd,
    input  logic              mw_we,
    input  logic [ADDR_W-1:0] mw_rd,
    output fwd_src_e          sel
);
    logic em_hit;
    logic mw_hit;

    always_comb begin
        em_hit = em_we && (em_rd != '0) && (em_rd == src_reg);
        mw_hit = mw_we && (mw_rd != '0) && (mw_rd == src_reg);
        // newer producer first
        if (em_hit)
            sel = SRC_EXMEM;
        else if (mw_hit)
            sel = SRC_MEMWB;
        else
            sel = SRC_FILE;
    end

    always_comb begin
        if (src_reg == '0)
            assert_zero_never_fwd_R5: assert (sel == SRC_FILE);
        if (!em_we && !mw_we)
            assert_no_we_no_fwd_R4: assert (sel == SRC_FILE);
    end
endmodule

// File: rtl/operand_mux.sv
module operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_src_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] em_val,
    input  logic [DATA_W-1:0] mw_val,
    output logic [DATA_W-1:0] out_val
);
    always_comb begin
        unique case (sel)
            SRC_EXMEM: out_val = em_val;
            SRC_MEMWB: out_val = mw_val;
            SRC_FILE:  out_val = rf_val;
            default:   out_val = rf_val;
        endcase
    end
endmodule

// File: rtl/bypass_regfile.sv
module bypass_regfile #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int NREGS = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem_q [NREGS];
    logic              wr_live;

    assign wr_live = we && (waddr != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++)
                mem_q[i] <= '0;
        end else if (wr_live) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        if (raddr_a == '0)
            rdata_a = '0;
        else if (wr_live && (waddr == raddr_a))
            rdata_a = wdata;
        else
            rdata_a = mem_q[raddr_a];

        if (raddr_b == '0)
            rdata_b = '0;
        else if (wr_live && (waddr == raddr_b))
            rdata_b = wdata;
        else
            rdata_b = mem_q[raddr_b];
    end

    assert_write_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr != '0)) |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rs_addr,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              em_we,
    input  logic [ADDR_W-1:0] em_rd,
    input  logic [DATA_W-1:0] em_data,
    input  logic              mw_we,
    input  logic [ADDR_W-1:0] mw_rd,
    input  logic [DATA_W-1:0] mw_data,
    input  logic              wb_we,
    input  logic [ADDR_W-1:0] wb_rd,
    input  logic [DATA_W-1:0] wb_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int NOPND = 2;

    logic [ADDR_W-1:0] src_w [NOPND];
    logic [DATA_W-1:0] rf_w  [NOPND];
    logic [DATA_W-1:0] out_w [NOPND];
    fwd_src_e          sel_w [NOPND];

    assign src_w[0] = rs_addr;
    assign src_w[1] = rt_addr;

    bypass_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wb_we),
        .waddr   (wb_rd),
        .wdata   (wb_data),
        .raddr_a (rs_addr),
        .raddr_b (rt_addr),
        .rdata_a (rf_w[0]),
        .rdata_b (rf_w[1])
    );

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        fwd_select #(.ADDR_W(ADDR_W)) u_sel (
            .src_reg (src_w[g]),
            .em_we   (em_we),
            .em_rd   (em_rd),
            .mw_we   (mw_we),
            .mw_rd   (mw_rd),
            .sel     (sel_w[g])
        );
        operand_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_w[g]),
            .rf_val  (rf_w[g]),
            .em_val  (em_data),
            .mw_val  (mw_data),
            .out_val (out_w[g])
        );
    end

    assign sel_a  = sel_w[0];
    assign sel_b  = sel_w[1];
    assign opnd_a = out_w[0];
    assign opnd_b = out_w[1];

    always_comb begin
        if (rst_n) begin
            assert_sel_legal_R1: assert ($onehot0(sel_a) && $onehot0(sel_b));
            if (sel_a == 2'b10)
                assert_em_value_a_R1: assert (opnd_a == em_data);
            if (sel_b == 2'b01)
                assert_mw_value_b_R2: assert (opnd_b == mw_data);
            if (sel_a == 2'b00)
                assert_file_value_a_R3: assert (opnd_a == rf_w[0]);
        end
    end
endmodule

// File: tb/fwd_unit_top_bench.sv
module fwd_unit_top_bench;
    localparam int DW = 32;
    localparam logic [DW-1:0] EM_D = 32'hE3E3_0001;
    localparam logic [DW-1:0] MW_D = 32'h3A3A_0002;

    typedef struct packed {
        logic       emwe;
        logic [4:0] emrd;
        logic       mwwe;
        logic [4:0] mwrd;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [1:0] ea;
        logic [1:0] eb;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd3,  1'b0, 5'd0,  5'd3,  5'd4,  2'b10, 2'b00, 8'd1}, // R1
        '{1'b0, 5'd0,  1'b1, 5'd4,  5'd3,  5'd4,  2'b00, 2'b01, 8'd2}, // R2
        '{1'b1, 5'd6,  1'b1, 5'd6,  5'd6,  5'd6,  2'b10, 2'b10, 8'd6}, // R6
        '{1'b0, 5'd6,  1'b1, 5'd6,  5'd6,  5'd6,  2'b01, 2'b01, 8'd4}, // R4
        '{1'b1, 5'd0,  1'b1, 5'd0,  5'd0,  5'd0,  2'b00, 2'b00, 8'd5}, // R5
        '{1'b0, 5'd9,  1'b0, 5'd9,  5'd9,  5'd9,  2'b00, 2'b00, 8'd4}, // R4
        '{1'b1, 5'd10, 1'b1, 5'd11, 5'd11, 5'd10, 2'b01, 2'b10, 8'd7}, // R7
        '{1'b1, 5'd12, 1'b1, 5'd13, 5'd14, 5'd15, 2'b00, 2'b00, 8'd3}, // R3
        '{1'b1, 5'd0,  1'b1, 5'd17, 5'd0,  5'd17, 2'b00, 2'b01, 8'd5}, // R5
        '{1'b1, 5'd20, 1'b1, 5'd20, 5'd20, 5'd21, 2'b10, 2'b00, 8'd6}, // R6
        '{1'b1, 5'd31, 1'b1, 5'd30, 5'd30, 5'd31, 2'b01, 2'b10, 8'd7}  // R7
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rs_addr = '0, rt_addr = '0, em_rd = '0, mw_rd = '0, wb_rd = '0;
    logic          em_we = 1'b0, mw_we = 1'b0, wb_we = 1'b0;
    logic [DW-1:0] em_data = EM_D, mw_data = MW_D, wb_data = '0;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fwd_unit_top u_fwd_unit_top (
        .clk(clk), .rst_n(rst_n),
        .rs_addr(rs_addr), .rt_addr(rt_addr),
        .em_we(em_we), .em_rd(em_rd), .em_data(em_data),
        .mw_we(mw_we), .mw_rd(mw_rd), .mw_data(mw_data),
        .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    function automatic logic [DW-1:0] file_val(input logic [4:0] r);
        return (r == 5'd0) ? '0 : (32'h1000_0000 + 32'(r));
    endfunction

    function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [4:0] r);
        case (s)
            2'b10:   return EM_D;
            2'b01:   return MW_D;
            default: return file_val(r);
        endcase
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10: registers zero while and after reset
        rs_addr = 5'd5; rt_addr = 5'd31;
        #20;
        check("R10", opnd_a, '0);
        check("R10", opnd_b, '0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        check("R10", opnd_a, '0);
        check("R3", {30'd0, sel_a}, 32'd0);

        // preload registers 1..31
        for (int r = 1; r < 32; r++) begin
            @(negedge clk);
            wb_we = 1'b1; wb_rd = 5'(r); wb_data = file_val(5'(r));
        end
        @(negedge clk); wb_we = 1'b0;

        // R9: stored values come back on later reads
        rs_addr = 5'd1; rt_addr = 5'd31; #1;
        check("R9", opnd_a, file_val(5'd1));
        check("R9", opnd_b, file_val(5'd31));

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            em_we = VECS[i].emwe; em_rd = VECS[i].emrd;
            mw_we = VECS[i].mwwe; mw_rd = VECS[i].mwrd;
            rs_addr = VECS[i].rs; rt_addr = VECS[i].rt;
            #1;
            check($sformatf("R%0d sel_a", VECS[i].req), {30'd0, sel_a}, {30'd0, VECS[i].ea});
            check($sformatf("R%0d sel_b", VECS[i].req), {30'd0, sel_b}, {30'd0, VECS[i].eb});
            check($sformatf("R%0d opnd_a", VECS[i].req), opnd_a, pick(VECS[i].ea, VECS[i].rs));
            check($sformatf("R%0d opnd_b", VECS[i].req), opnd_b, pick(VECS[i].eb, VECS[i].rt));
        end

        // R8: same-cycle write/read bypass, no forwarding active
        @(negedge clk);
        em_we = 1'b0; mw_we = 1'b0;
        wb_we = 1'b1; wb_rd = 5'd7; wb_data = 32'hCAFE_0707;
        rs_addr = 5'd7; rt_addr = 5'd8; #1;
        check("R8", opnd_a, 32'hCAFE_0707);
        check("R8", opnd_b, file_val(5'd8));
        @(negedge clk); wb_we = 1'b0; #1;
        check("R9", opnd_a, 32'hCAFE_0707);

        // R9/R5: write to register 0 is neither bypassed nor stored
        @(negedge clk);
        wb_we = 1'b1; wb_rd = 5'd0; wb_data = 32'hDEAD_0000;
        rs_addr = 5'd0; rt_addr = 5'd0; #1;
        check("R9", opnd_a, '0);
        @(negedge clk); wb_we = 1'b0; #1;
        check("R9", opnd_b, '0);

        // R6 with data from register file bypass also present: forward still wins
        @(negedge clk);
        em_we = 1'b1; em_rd = 5'd9; mw_we = 1'b1; mw_rd = 5'd9;
        wb_we = 1'b1; wb_rd = 5'd9; wb_data = 32'h0909_0909;
        rs_addr = 5'd9; rt_addr = 5'd9; #1;
        check("R6", opnd_a, EM_D);
        check("R6", opnd_b, EM_D);
        @(negedge clk); wb_we = 1'b0; em_we = 1'b0; mw_we = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule